// File: doc/BRIEF.md
# Sector Protection Bit Controller

This block keeps the write-protection state of each sector of a small flash-style memory array. Each sector has two bits. The dynamic bit is volatile: it returns to 0 on reset. The persistent bit keeps its value across reset. The persistent bits are modelled as registers that hold their value from power-up and are not touched by the reset input. A single global lock freezes every persistent bit. A command can set the lock, but only the reset input can clear it. The reset input stands for a power cycle or a hardware reset.

A requester gives one request at a time: an operation code and a sector index, qualified by a valid strobe. The request is taken only while the block reports ready. The block works on it in the following cycle and then raises an acknowledge for one cycle. If the request breaks a rule, an error pulse goes with that acknowledge and no state changes. The per-sector protected flags are the OR of the two bits for each sector. The memory core reads these flags to decide whether a sector may be written.

Top module: `sector_guard`

## Requirements
- R1: While `rst_n` is low and after it rises, every dynamic bit is 0, `lock_o` is 0, `ack` and `err` are 0, and `req_ready` is 1. Every persistent bit keeps the value it had before reset.
- R2: For each sector i, `prot[i]` is 1 exactly when its persistent bit or its dynamic bit is 1. A sector with both bits at 0 reports 0.
- R3: Op code 0 sets and op code 1 clears the dynamic bit of the sector at `req_sector`. Both are accepted without error whether `lock_o` is 0 or 1.
- R4: While `lock_o` is 0, op code 2 sets and op code 3 clears the persistent bit of the addressed sector, without error.
- R5: Op code 4 sets `lock_o` and is accepted even when the lock is already set. Once `lock_o` is 1 it stays 1 until `rst_n` goes low. After reset, op codes 2 and 3 are accepted again.
- R6: While `lock_o` is 1, op codes 2 and 3 end with `err` high together with `ack`, and every persistent bit and every dynamic bit stays unchanged.
- R7: A request is captured at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for one cycle. At the next edge the state update happens and `ack` is 1 for exactly one cycle, once for each captured request.
- R8: `err` is only ever 1 together with `ack`. Op codes 5, 6 and 7 end with `err` high and leave all state unchanged.
- R9: At power-up, before any request, the persistent bits hold the parameter `PERSIST_INIT` (default all 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, stands for power cycle or hardware reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code: 0 dyn set, 1 dyn clear, 2 persistent set, 3 persistent clear, 4 lock set |
| req_sector | input | $clog2(SECTORS) | Sector index of the request |
| req_ready | output | 1 | High when no request is pending |
| ack | output | 1 | One-cycle pulse when a request has been processed |
| err | output | 1 | One-cycle pulse with `ack` when the request was rejected |
| lock_o | output | 1 | Global persistent-bit lock |
| prot | output | SECTORS | Per-sector protected flag |

## Verification
The bench drives the block with five kinds of stimulus. Single set and clear requests with the lock clear show that each bit type changes on its own sector only. The same requests with the lock set separate the frozen persistent bits from the dynamic bits, which must still change. Invalid op codes are sent to check that they are rejected. A valid strobe held high for several cycles checks that one acknowledge comes for every captured request and that the ready gating holds. A reset in the middle of the run separates the dynamic bits and the lock, which are cleared, from the persistent bits, which are kept. After that reset the persistent bits must be writable again.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [2:0] {
      OP_DYN_SET  = 3'd0,
      OP_DYN_CLR  = 3'd1,
      OP_PERS_SET = 3'd2,
      OP_PERS_CLR = 3'd3,
      OP_LOCK_SET = 3'd4
   } sg_op_e;

   typedef struct packed {
      logic wr_dyn;
      logic wr_pers;
      logic val;
      logic set_lock;
      logic reject;
   } sg_act_t;
endpackage

// File: rtl/sg_req_stage.sv
module sg_req_stage #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_op,
   input  logic [IDX_W-1:0] in_idx,
   output logic             ready,
   output logic             pend,
   output logic [2:0]       held_op,
   output logic [IDX_W-1:0] held_idx
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         held_op  <= '0;
         held_idx <= '0;
      end else if (!pend_q && in_valid) begin
         pend_q   <= 1'b1;
         held_op  <= in_op;
         held_idx <= in_idx;
      end else begin
         pend_q   <= 1'b0;
      end
   end

   assign ready = !pend_q;
   assign pend  = pend_q;
endmodule

// File: rtl/sg_decide.sv
module sg_decide
   import sg_pkg::*;
#(
   parameter int SECTORS = 8,
   parameter int IDX_W   = 3
) (
   input  logic               pend,
   input  logic [2:0]         op,
   input  logic [IDX_W-1:0]   idx,
   input  logic               lock,
   output sg_act_t            act,
   output logic [SECTORS-1:0] sel
);
   localparam bit FULL_RANGE = (SECTORS == (1 << IDX_W));

   logic idx_ok;

   generate
      if (FULL_RANGE) begin : g_full
         assign idx_ok = 1'b1;
      end else begin : g_part
         assign idx_ok = (int'(idx) < SECTORS);
      end
   endgenerate

   always_comb begin
      act = '0;
      if (pend) begin
         unique case (op)
            OP_DYN_SET:  begin act.wr_dyn  = idx_ok; act.val = 1'b1; end
            OP_DYN_CLR:  begin act.wr_dyn  = idx_ok; act.val = 1'b0; end
            OP_PERS_SET: begin act.wr_pers = idx_ok && !lock; act.val = 1'b1; end
            OP_PERS_CLR: begin act.wr_pers = idx_ok && !lock; act.val = 1'b0; end
            OP_LOCK_SET: act.set_lock = 1'b1;
            default:     act.reject = 1'b1;
         endcase
         if ((op == OP_PERS_SET || op == OP_PERS_CLR) && lock) act.reject = 1'b1;
         if (op != OP_LOCK_SET && !idx_ok) act.reject = 1'b1;
      end
   end

   always_comb begin
      sel = '0;
      for (int i = 0; i < SECTORS; i++) sel[i] = (int'(idx) == i);
   end
endmodule

// File: rtl/sg_bit_bank.sv
module sg_bit_bank #(
   parameter int               SECTORS      = 8,
   parameter logic [SECTORS-1:0] PERSIST_INIT = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SECTORS-1:0] sel,
   input  logic               wr_dyn,
   input  logic               wr_pers,
   input  logic               val,
   output logic [SECTORS-1:0] dyn,
   output logic [SECTORS-1:0] keep,
   output logic [SECTORS-1:0] prot
);
   generate
      for (genvar g = 0; g < SECTORS; g++) begin : g_sec
         logic dyn_r;
         logic keep_r = PERSIST_INIT[g];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                dyn_r <= 1'b0;
            else if (wr_dyn && sel[g]) dyn_r <= val;
         end

         always_ff @(posedge clk) begin
            if (wr_pers && sel[g]) keep_r <= val;
         end

         assign dyn[g]  = dyn_r;
         assign keep[g] = keep_r;
         assign prot[g] = dyn_r | keep_r;
      end
   endgenerate
endmodule

// File: rtl/sector_guard.sv
module sector_guard
   import sg_pkg::*;
#(
   parameter int                 SECTORS      = 8,
   parameter logic [SECTORS-1:0] PERSIST_INIT = '0,
   localparam int                IDX_W        = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [2:0]         req_op,
   input  logic [IDX_W-1:0]   req_sector,
   output logic               req_ready,
   output logic               ack,
   output logic               err,
   output logic               lock_o,
   output logic [SECTORS-1:0] prot
);
   generate
      if (SECTORS < 1 || SECTORS > 256) begin : g_bad_size
         $error("sector_guard: SECTORS must lie in 1..256");
      end
   endgenerate

   logic               pend;
   logic [2:0]         held_op;
   logic [IDX_W-1:0]   held_idx;
   sg_act_t            act;
   logic [SECTORS-1:0] sel;
   logic [SECTORS-1:0] dyn_w;
   logic [SECTORS-1:0] keep_w;
   logic               lock_q;
   logic               ack_q;
   logic               err_q;

   sg_req_stage #(.IDX_W(IDX_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (req_valid),
      .in_op    (req_op),
      .in_idx   (req_sector),
      .ready    (req_ready),
      .pend     (pend),
      .held_op  (held_op),
      .held_idx (held_idx)
   );

   sg_decide #(.SECTORS(SECTORS), .IDX_W(IDX_W)) u_decide (
      .pend (pend),
      .op   (held_op),
      .idx  (held_idx),
      .lock (lock_q),
      .act  (act),
      .sel  (sel)
   );

   sg_bit_bank #(.SECTORS(SECTORS), .PERSIST_INIT(PERSIST_INIT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr_dyn  (act.wr_dyn),
      .wr_pers (act.wr_pers),
      .val     (act.val),
      .dyn     (dyn_w),
      .keep    (keep_w),
      .prot    (prot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         ack_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (act.set_lock) lock_q <= 1'b1;
         ack_q <= pend;
         err_q <= act.reject;
      end
   end

   assign lock_o = lock_q;
   assign ack    = ack_q;
   assign err    = err_q;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int SECTORS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               ack,
   input logic               err,
   input logic               lock,
   input logic [SECTORS-1:0] keep,
   input logic [SECTORS-1:0] dyn
);
   assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   assert_pending_acks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ack);

   assert_err_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ack);

   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   assert_keep_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(keep));

   assert_dyn_only_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> $stable(dyn));
endmodule

bind sector_guard sg_checker #(.SECTORS(SECTORS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .ack       (ack),
   .err       (err),
   .lock      (lock_o),
   .keep      (keep_w),
   .dyn       (dyn_w)
);

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
   localparam int N = 8;
   localparam int W = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [2:0]   req_op = '0;
   logic [W-1:0] req_sector = '0;
   logic         req_ready, ack, err, lock_o;
   logic [N-1:0] prot;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit model_on = 1'b0;

   always #4 clk = ~clk;

   sector_guard #(.SECTORS(N)) i_sector_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_sector(req_sector), .req_ready(req_ready), .ack(ack), .err(err),
      .lock_o(lock_o), .prot(prot)
   );

   // behavioural reference
   logic [N-1:0] m_dyn = '0, m_pers = '0;
   logic m_lock = 0, m_pend = 0, m_ack = 0, m_err = 0;
   int   m_op = 0, m_sec = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dyn = '0; m_lock = 0; m_pend = 0; m_ack = 0; m_err = 0;
         model_on = 1'b1;
      end else begin
         m_ack = 0; m_err = 0;
         if (m_pend) begin
            m_ack = 1; m_pend = 0;
            case (m_op)
               0: m_dyn[m_sec] = 1'b1;
               1: m_dyn[m_sec] = 1'b0;
               2, 3: if (m_lock) m_err = 1; else m_pers[m_sec] = (m_op == 2);
               4: m_lock = 1;
               default: m_err = 1;
            endcase
         end else if (req_valid) begin
            m_pend = 1; m_op = int'(req_op); m_sec = int'(req_sector);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (model_on) begin
         chk(prot == (m_dyn | m_pers), "R2", int'(prot), int'(m_dyn | m_pers));
         chk(lock_o == m_lock, "R5", int'(lock_o), int'(m_lock));
         chk(ack == m_ack, "R7", int'(ack), int'(m_ack));
         chk(req_ready == !m_pend, "R7", int'(req_ready), int'(!m_pend));
         chk(err == m_err, "R8", int'(err), int'(m_err));
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic send(input int op, input int sec);
      @(negedge clk); #1;
      req_valid = 1'b1; req_op = 3'(op); req_sector = W'(sec);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(ack == 1'b1, "R7", int'(ack), 1);
   endtask

   task automatic do_reset();
      @(negedge clk); #1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(lock_o == 1'b0 && ack == 1'b0 && err == 1'b0 && req_ready == 1'b1,
          "R1", int'({lock_o, ack, err, req_ready}), 1);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      int acks;
      do_reset();
      @(negedge clk);
      chk(prot == '0, "R9", int'(prot), 0);

      send(0, 5);  chk(prot[5] && !err, "R3", int'(prot), 8'h20);
      send(2, 3);  chk(prot[3] && !err, "R4", int'(prot), 8'h28);
      send(3, 3);  chk(!prot[3] && !err, "R4", int'(prot), 8'h20);
      send(2, 3);  chk(prot[3], "R4", int'(prot), 8'h28);
      send(1, 5);  chk(prot == 8'h08, "R2", int'(prot), 8'h08);
      send(4, 0);  chk(lock_o && !err, "R5", int'(lock_o), 1);
      send(4, 0);  chk(lock_o && !err, "R5", int'(err), 0);
      send(3, 3);  chk(err && prot == 8'h08, "R6", int'({err, prot}), 9'h108);
      send(2, 6);  chk(err && prot == 8'h08, "R6", int'({err, prot}), 9'h108);
      send(0, 0);  chk(!err && prot == 8'h09, "R3", int'(prot), 8'h09);
      send(1, 0);  chk(!err && prot == 8'h08, "R3", int'(prot), 8'h08);
      send(6, 2);  chk(err && prot == 8'h08, "R8", int'({err, prot}), 9'h108);
      send(7, 1);  chk(err, "R8", int'(err), 1);

      // held strobe: one ack per captured request
      @(negedge clk); #1;
      req_valid = 1'b1; req_op = 3'd0; req_sector = 3'd1;
      acks = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (ack) acks++;
      end
      #1 req_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(acks == 3, "R7", acks, 3);

      do_reset();
      @(negedge clk);
      chk(prot == 8'h08 && !lock_o, "R1", int'({lock_o, prot}), 8'h08);
      send(3, 3);  chk(!err && prot == 8'h00, "R5", int'(prot), 0);
      send(2, 7);  chk(!err && prot == 8'h80, "R4", int'(prot), 8'h80);

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule